// File: doc/BRIEF.md
# Ticket Lock Unit

This block is a hardware mutual-exclusion lock shared by a fixed set of requesters and served strictly first come, first served. It keeps two wrapping counters: the number of the next ticket to hand out, and the number of the ticket now being served. A requester that pulses its acquire line is given the current ticket number in that clock edge, and the ticket counter moves forward. The requester's grant line rises once the serving counter reaches its ticket. When the holder pulses its release line, the serving counter advances and the lock passes to the holder of the next ticket.

Acquires that arrive in the same cycle get consecutive tickets, with the lowest requester index taking the lowest ticket. A requester that already holds a ticket, whether granted or still waiting, cannot take a second one; that request is dropped. A release from a requester that does not hold the grant changes nothing, and it raises a one-cycle error flag. All pins are plain level or pulse controls. No data flows through the block, so there is no valid/ready handshake and no back-pressure: every pulse is acted on, or dropped by the rules above, in the edge that samples it.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset, every grant and the error flag are low, both counters are zero, and no requester holds a ticket.
- R2: An acquire from a requester with no ticket, sampled at a clock edge, assigns it the current ticket number and increments the ticket counter. If that ticket equals the serving counter, the grant is high from that edge on.
- R3: At most one grant is high in any cycle. A requester's grant is high only while it holds a ticket equal to the serving counter.
- R4: A release from the granted requester, sampled at an edge, drops its grant and frees its ticket from that edge on. It also increments the serving counter, so the next ticket's holder, if any, is granted from that same edge. A holder that does not release keeps its grant.
- R5: Acquires sampled at the same edge receive consecutive tickets in ascending requester-index order (index 0 first), so they are served in that order.
- R6: A release from a requester that is not granted is ignored, and the serving counter and all grants are unchanged. The error flag is high for the one cycle after the edge that sampled any such release, and low otherwise.
- R7: An acquire from a requester that already holds a ticket is ignored. This includes the holder releasing in the same cycle. No ticket is consumed, and service order is unaffected.
- R8: Both counters are TKT_W bits wide and wrap modulo 2^TKT_W. TKT_W must satisfy 2^TKT_W >= N_REQ, and ticket matching stays correct across the wrap.
- R9: Over any pattern of acquires and releases, grants are given in exactly the order tickets were taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_i | input | N_REQ | Per-requester acquire pulse |
| rel_i | input | N_REQ | Per-requester release pulse |
| grant_o | output | N_REQ | Per-requester lock grant, at most one high |
| rel_err_o | output | 1 | Pulse: a release arrived from a non-holder |

## Verification
All results are due one edge after the stimulus. Grants come from registered ticket and serving state through a comparator, and the error flag is a register, so both settle after the edge that samples acq_i and rel_i. The bench drives inputs at a falling edge, lets one rising edge pass, and compares grants and the error flag at the next falling edge. It compares them against an arrival queue that the bench keeps and updates by the requirement rules. The directed steps are followed by a sweep over every acquire and release pattern of a four-requester, three-bit configuration, which wraps the counters many times.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  // Count set bits of v strictly below position idx.
  function automatic int ones_below(input logic [31:0] v, input int idx);
    int c;
    c = 0;
    for (int k = 0; k < 32; k++) begin
      if (k < idx && v[k]) c++;
    end
    return c;
  endfunction
endpackage

// File: rtl/ticket_dispenser.sv
module ticket_dispenser #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_REQ-1:0]              take_i,
  output logic [N_REQ-1:0][TKT_W-1:0]   tkt_o
);
  import tlk_pkg::*;

  logic [TKT_W-1:0] next_q;

  // Each taker gets next + (number of lower-index takers): index order.
  always_comb begin
    for (int i = 0; i < N_REQ; i++) begin
      tkt_o[i] = next_q + TKT_W'(ones_below(32'(take_i), i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) next_q <= '0;
    else        next_q <= next_q + TKT_W'($countones(take_i));
  end
endmodule

// File: rtl/holder_slot.sv
module holder_slot #(
  parameter int TKT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [TKT_W-1:0] tkt_in_i,
  input  logic             drop_i,
  input  logic [TKT_W-1:0] serving_i,
  output logic             pending_o,
  output logic             grant_o
);
  logic             pend_q;
  logic [TKT_W-1:0] tkt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tkt_q  <= '0;
    end else if (drop_i) begin
      pend_q <= 1'b0;
    end else if (take_i) begin
      pend_q <= 1'b1;
      tkt_q  <= tkt_in_i;
    end
  end

  assign pending_o = pend_q;
  assign grant_o   = pend_q && (tkt_q == serving_i);
endmodule

// File: rtl/serve_counter.sv
module serve_counter #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] rel_i,
  input  logic [N_REQ-1:0] grant_i,
  output logic [TKT_W-1:0] serving_o,
  output logic             err_o
);
  logic [TKT_W-1:0] serving_q;
  logic             err_q;
  logic             advance;
  logic             stray;

  assign advance = |(rel_i & grant_i);
  assign stray   = |(rel_i & ~grant_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serving_q <= '0;
      err_q     <= 1'b0;
    end else begin
      if (advance) serving_q <= serving_q + TKT_W'(1);
      err_q <= stray;
    end
  end

  assign serving_o = serving_q;
  assign err_o     = err_q;
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
  parameter int N_REQ = 4,
  parameter int TKT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_REQ-1:0] acq_i,
  input  logic [N_REQ-1:0] rel_i,
  output logic [N_REQ-1:0] grant_o,
  output logic             rel_err_o
);
  logic [N_REQ-1:0]            pending;
  logic [N_REQ-1:0]            take;
  logic [N_REQ-1:0]            drop;
  logic [N_REQ-1:0][TKT_W-1:0] tkt_all;
  logic [TKT_W-1:0]            serving;

  assign take = acq_i & ~pending;
  assign drop = rel_i & grant_o;

  ticket_dispenser #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_disp (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take),
    .tkt_o  (tkt_all)
  );

  for (genvar g = 0; g < N_REQ; g++) begin : g_slot
    holder_slot #(.TKT_W(TKT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_i    (take[g]),
      .tkt_in_i  (tkt_all[g]),
      .drop_i    (drop[g]),
      .serving_i (serving),
      .pending_o (pending[g]),
      .grant_o   (grant_o[g])
    );
  end

  serve_counter #(.N_REQ(N_REQ), .TKT_W(TKT_W)) u_serve (
    .clk       (clk),
    .rst_n     (rst_n),
    .rel_i     (rel_i),
    .grant_i   (grant_o),
    .serving_o (serving),
    .err_o     (rel_err_o)
  );
endmodule

// File: rtl/tlk_checker.sv
module tlk_checker #(
  parameter int N_REQ = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_REQ-1:0] acq_i,
  input logic [N_REQ-1:0] rel_i,
  input logic [N_REQ-1:0] grant_o,
  input logic             rel_err_o
);
  p_one_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_holder_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & ~rel_i) != '0) |=>
      ((grant_o & $past(grant_o & ~rel_i)) == $past(grant_o & ~rel_i)));

  p_release_drops_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((rel_i & grant_o) != '0) |=> ((grant_o & $past(rel_i & grant_o)) == '0));

  p_stray_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rel_i & ~grant_o) != '0) |=> rel_err_o);

  p_no_stray_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((rel_i & ~grant_o) == '0) |=> !rel_err_o);

  p_waiter_not_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (((grant_o & ~rel_i) != '0) && ((acq_i & ~grant_o) != '0)) |=>
      ((grant_o & $past(acq_i & ~grant_o)) == '0));
endmodule

bind ticket_lock_unit tlk_checker #(.N_REQ(N_REQ)) u_tlk_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .acq_i     (acq_i),
  .rel_i     (rel_i),
  .grant_o   (grant_o),
  .rel_err_o (rel_err_o)
);

// File: tb/ticket_lock_unit_bench.sv
`timescale 1ns/1ps
module ticket_lock_unit_bench;
  localparam int N = 4;
  localparam int W = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] acq = '0;
  logic [N-1:0] rel = '0;
  logic [N-1:0] grant;
  logic         err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench model: queue of requester indices in ticket order.
  int           q [16];
  int           qh = 0;
  int           qn = 0;
  logic [N-1:0] mpend = '0;

  always #10 clk = ~clk;

  ticket_lock_unit #(.N_REQ(N), .TKT_W(W)) u_ticket_lock_unit (
    .clk       (clk),
    .rst_n     (rst_n),
    .acq_i     (acq),
    .rel_i     (rel),
    .grant_o   (grant),
    .rel_err_o (err)
  );

  function automatic logic [N-1:0] model_grant();
    if (qn > 0) return N'(1 << q[qh]);
    return '0;
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] a, input logic [N-1:0] r, input string tag);
    logic [N-1:0] g_now, oldp;
    logic         eerr;
    g_now = model_grant();
    oldp  = mpend;
    eerr  = |(r & ~g_now);
    acq = a;
    rel = r;
    if (|(r & g_now)) begin
      mpend[q[qh]] = 1'b0;
      qh = (qh + 1) % 16;
      qn--;
    end
    for (int i = 0; i < N; i++) begin
      if (a[i] && !oldp[i]) begin
        q[(qh + qn) % 16] = i;
        qn++;
        mpend[i] = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    chk(32'(grant), 32'(model_grant()), {tag, " grant"});
    chk(32'(err), 32'(eerr), {tag, " rel_err"});
    acq = '0;
    rel = '0;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(32'(grant), 0, "R1 grant after reset");
    chk(32'(err), 0, "R1 rel_err after reset");
    step('0, '0, "R1 idle");
    // R2: first acquire gets ticket 0 and is granted
    step(4'b0001, '0, "R2 first acquire");
    // R7: re-acquire while holding is dropped
    step(4'b0001, '0, "R7 reacquire holder");
    step(4'b0100, '0, "R7 waiter joins");
    step(4'b0100, '0, "R7 reacquire waiter");
    // R7: holder releases and re-acquires in one cycle: acquire dropped
    step(4'b0001, 4'b0001, "R7 release+acquire");
    step('0, 4'b0100, "R4 waiter release");
    step('0, '0, "R4 empty after release");
    // R5: simultaneous acquires in index order
    step(4'b1111, '0, "R5 all acquire");
    step('0, 4'b0001, "R5 pass to 1");
    step('0, 4'b0010, "R5 pass to 2");
    // R6: stray release ignored, flag one cycle
    step('0, 4'b1001, "R6 stray release");
    step('0, '0, "R6 flag clears");
    step('0, 4'b0100, "R5 pass to 3");
    step('0, 4'b1000, "R4 last release");
    // R9: staggered arrivals
    step(4'b1000, '0, "R9 arrive 3");
    step(4'b0010, '0, "R9 arrive 1");
    step(4'b0101, '0, "R9 arrive 0 and 2");
    step('0, 4'b1000, "R9 serve next");
    step('0, 4'b0010, "R9 serve next");
    step('0, 4'b0001, "R9 serve next");
    step('0, 4'b0100, "R9 serve last");
    // R3 R8 R9: sweep every acquire/release pattern, wrapping counters
    for (int s = 0; s < 3; s++) begin
      for (int a = 0; a < 16; a++) begin
        for (int r = 0; r < 16; r++) begin
          step(4'(a), 4'(r ^ (s * 5)), "R3 R8 R9 sweep");
        end
      end
    end
    // drain: release holders in turn (R8 wrap exercised above)
    for (int k = 0; k < 8; k++) step('0, model_grant(), "R8 drain");
    chk(32'(grant), 0, "R4 drained");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule